// File: doc/BRIEF.md
# Banked Bit-Addressable Data RAM

A 128-byte on-chip data store for an 8-bit controller core. It offers three concurrent views of the same bytes. The byte view takes a full 7-bit address. The register view takes a 3-bit register number and a 2-bit bank taken from an internal status byte. The bit view reaches single bits of a 16-byte window. Every read is combinational from the stored array, and every write takes effect on the next rising clock edge.

The register view places the eight registers of the selected bank in the lowest 32 bytes. Banks that are not selected stay reachable as plain bytes. The bit view can read one bit, or set, clear or load one bit, in a single cycle, and it leaves the other seven bits of the byte intact. Bytes from 30h upward have no special meaning and are reached only through the byte view. Reset returns only the status byte to zero; the stored data survives reset.

Top module: `iram_core`

## Requirements
- R1: While rst_ni is low, and after it is released, stat_o reads 00h and bank_o reads 0.
- R2: When stat_we_i is high, stat_o takes stat_wdata_i on the next edge. bank_o is {stat_o[4], stat_o[3]}, with bit 4 as the high select bit.
- R3: The register view addresses byte 8*bank_o + reg_num_i. reg_rdata_o shows that byte combinationally, and a write with reg_we_i lands there on the next edge.
- R4: Bytes of banks that are not selected can still be read and written through the byte view, and a byte view write is seen by the register view once its bank is selected.
- R5: byte_rdata_o shows the byte at byte_addr_i combinationally, for any address 00h–7Fh. A write with byte_we_i is visible from the next edge.
- R6: Bit address b selects byte 20h + (b >> 3), bit position b & 7, and bit_rdata_o shows that bit. For example, bit 4Eh is bit 6 of byte 29h.
- R7: bit_op_i encodes 0 as no write, 1 as set, 2 as clear and 3 as load bit_wdata_i. A bit write changes only the addressed bit of the byte.
- R8: If two views write the same byte in one cycle, the register view data replaces the byte view data, and a bit write is then applied on top.
- R9: Reset does not alter the stored bytes.
- R10: A register write in the same cycle as a status write uses the bank in effect before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_we_i | input | 1 | Status byte write enable |
| stat_wdata_i | input | 8 | Status byte write data |
| stat_o | output | 8 | Current status byte |
| bank_o | output | 2 | Selected register bank |
| byte_addr_i | input | 7 | Byte view address |
| byte_we_i | input | 1 | Byte view write enable |
| byte_wdata_i | input | 8 | Byte view write data |
| byte_rdata_o | output | 8 | Byte view read data |
| reg_num_i | input | 3 | Register number in the selected bank |
| reg_we_i | input | 1 | Register view write enable |
| reg_wdata_i | input | 8 | Register view write data |
| reg_rdata_o | output | 8 | Register view read data |
| bit_addr_i | input | 7 | Bit address in the bit window |
| bit_op_i | input | 2 | Bit operation: 0 none, 1 set, 2 clear, 3 load |
| bit_wdata_i | input | 1 | Bit value for the load operation |
| bit_rdata_o | output | 1 | Addressed bit |

## Verification
The three read results are due in the same cycle as the address that selects them, with no register on the path. Writes from any view, and status writes, show up one edge later. The bench drives each stimulus just after a falling edge and compares all read ports 1 ns later against a model of the array and the status byte. It then updates the model at the rising edge, so that every read sees exactly the writes of the edges before it. The bank used by a register access is always the model's value before the edge, which is how the same-cycle case is judged.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam int unsigned REG_W     = 3;
  localparam int unsigned BANK_W    = 2;
  localparam int unsigned BANK_LSB  = 3;
  localparam int unsigned BIT_BASE  = 32;

  typedef enum logic [1:0] {
    BIT_NOP = 2'd0,
    BIT_SET = 2'd1,
    BIT_CLR = 2'd2,
    BIT_PUT = 2'd3
  } bit_op_e;
endpackage

// File: rtl/iram_bank_map.sv
module iram_bank_map #(
  parameter int unsigned REG_W  = iram_pkg::REG_W,
  parameter int unsigned BANK_W = iram_pkg::BANK_W,
  parameter int unsigned ADDR_W = iram_pkg::ADDR_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [REG_W-1:0]  reg_num_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned PAD_W = ADDR_W - BANK_W - REG_W;

  // bank n spans 8n..8n+7
  assign addr_o = {{PAD_W{1'b0}}, bank_i, reg_num_i};
endmodule

// File: rtl/iram_bit_map.sv
module iram_bit_map #(
  parameter int unsigned ADDR_W   = iram_pkg::ADDR_W,
  parameter int unsigned BYTE_W   = iram_pkg::BYTE_W,
  parameter int unsigned BIT_BASE = iram_pkg::BIT_BASE
) (
  input  logic [ADDR_W-1:0]         bit_addr_i,
  output logic [ADDR_W-1:0]         byte_addr_o,
  output logic [$clog2(BYTE_W)-1:0] bit_idx_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BIT_BASE);

  assign byte_addr_o = BASE_A + {{IDX_W{1'b0}}, bit_addr_i[ADDR_W-1:IDX_W]};
  assign bit_idx_o   = bit_addr_i[IDX_W-1:0];
endmodule

// File: rtl/iram_status.sv
module iram_status #(
  parameter int unsigned BYTE_W   = iram_pkg::BYTE_W,
  parameter int unsigned BANK_W   = iram_pkg::BANK_W,
  parameter int unsigned BANK_LSB = iram_pkg::BANK_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] q_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [BYTE_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stat_q <= '0;
    else if (we_i) stat_q <= wdata_i;
  end

  assign q_o    = stat_q;
  assign bank_o = stat_q[BANK_LSB +: BANK_W];

  p_stat_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i));

  p_stat_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int unsigned BYTE_W = iram_pkg::BYTE_W,
  parameter int unsigned ADDR_W = iram_pkg::ADDR_W,
  parameter int unsigned DEPTH  = iram_pkg::DEPTH
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      byte_we_i,
  input  logic [ADDR_W-1:0]         byte_addr_i,
  input  logic [BYTE_W-1:0]         byte_wdata_i,
  input  logic                      reg_we_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [BYTE_W-1:0]         reg_wdata_i,
  input  logic                      bit_we_i,
  input  logic [ADDR_W-1:0]         bit_byte_i,
  input  logic [$clog2(BYTE_W)-1:0] bit_idx_i,
  input  logic                      bit_val_i,
  output logic [BYTE_W-1:0]         byte_rdata_o,
  output logic [BYTE_W-1:0]         reg_rdata_o,
  output logic [BYTE_W-1:0]         bit_rbyte_o
);
  logic [BYTE_W-1:0] mem_w [DEPTH];

  // rst_ni only gates the checks; contents survive reset
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic              hit_byte, hit_reg, hit_bit;
    logic [BYTE_W-1:0] cell_q, cell_d;

    assign hit_byte = byte_we_i && (byte_addr_i == ADDR_W'(i));
    assign hit_reg  = reg_we_i  && (reg_addr_i  == ADDR_W'(i));
    assign hit_bit  = bit_we_i  && (bit_byte_i  == ADDR_W'(i));

    // merge order: byte, then register, then bit
    always_comb begin
      cell_d = cell_q;
      if (hit_byte) cell_d = byte_wdata_i;
      if (hit_reg)  cell_d = reg_wdata_i;
      if (hit_bit)  cell_d[bit_idx_i] = bit_val_i;
    end

    always_ff @(posedge clk_i) begin
      if (hit_byte || hit_reg || hit_bit) cell_q <= cell_d;
    end

    assign mem_w[i] = cell_q;
  end

  assign byte_rdata_o = mem_w[byte_addr_i];
  assign reg_rdata_o  = mem_w[reg_addr_i];
  assign bit_rbyte_o  = mem_w[bit_byte_i];

  p_byte_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && !(reg_we_i && reg_addr_i == byte_addr_i)
               && !(bit_we_i && bit_byte_i == byte_addr_i))
    |=> mem_w[$past(byte_addr_i)] == $past(byte_wdata_i));

  p_reg_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !(bit_we_i && bit_byte_i == reg_addr_i))
    |=> mem_w[$past(reg_addr_i)] == $past(reg_wdata_i));

  p_bit_val_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_we_i |=> mem_w[$past(bit_byte_i)][$past(bit_idx_i)] == $past(bit_val_i));

  p_bit_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_we_i && !(byte_we_i && byte_addr_i == bit_byte_i)
              && !(reg_we_i && reg_addr_i == bit_byte_i))
    |=> ((mem_w[$past(bit_byte_i)] ^ $past(bit_rbyte_o))
         & ~(BYTE_W'(1) << $past(bit_idx_i))) == '0);
endmodule

// File: rtl/iram_core.sv
module iram_core
  import iram_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stat_we_i,
  input  logic [7:0]  stat_wdata_i,
  output logic [7:0]  stat_o,
  output logic [1:0]  bank_o,
  input  logic [6:0]  byte_addr_i,
  input  logic        byte_we_i,
  input  logic [7:0]  byte_wdata_i,
  output logic [7:0]  byte_rdata_o,
  input  logic [2:0]  reg_num_i,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic [6:0]  bit_addr_i,
  input  logic [1:0]  bit_op_i,
  input  logic        bit_wdata_i,
  output logic        bit_rdata_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] reg_addr, bit_byte;
  logic [IDX_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] bit_rbyte;
  logic              bit_we, bit_val;

  iram_status #(.BYTE_W(BYTE_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (stat_we_i),
    .wdata_i (stat_wdata_i),
    .q_o     (stat_o),
    .bank_o  (bank)
  );

  iram_bank_map #(.REG_W(REG_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_bank_map (
    .bank_i    (bank),
    .reg_num_i (reg_num_i),
    .addr_o    (reg_addr)
  );

  iram_bit_map #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BIT_BASE(BIT_BASE)) u_bit_map (
    .bit_addr_i  (bit_addr_i),
    .byte_addr_o (bit_byte),
    .bit_idx_o   (bit_idx)
  );

  assign bit_we  = bit_op_i != BIT_NOP;
  assign bit_val = (bit_op_i == BIT_SET) || ((bit_op_i == BIT_PUT) && bit_wdata_i);

  iram_store #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_we_i    (byte_we_i),
    .byte_addr_i  (byte_addr_i),
    .byte_wdata_i (byte_wdata_i),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata_i),
    .bit_we_i     (bit_we),
    .bit_byte_i   (bit_byte),
    .bit_idx_i    (bit_idx),
    .bit_val_i    (bit_val),
    .byte_rdata_o (byte_rdata_o),
    .reg_rdata_o  (reg_rdata_o),
    .bit_rbyte_o  (bit_rbyte)
  );

  assign bank_o      = bank;
  assign bit_rdata_o = bit_rbyte[bit_idx];

  p_reg_view_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr == byte_addr_i) |-> (reg_rdata_o == byte_rdata_o));

  p_bank_old_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && reg_we_i && !bit_we && !(byte_we_i && byte_addr_i == reg_addr))
    |=> byte_rdata_o == byte_rdata_o && u_store.mem_w[{2'b00, $past(bank), $past(reg_num_i)}] == $past(reg_wdata_i));
endmodule

// File: tb/iram_core_tb_top.sv
module iram_core_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       stat_we_i = 0;  logic [7:0] stat_wdata_i = 0;
  logic [7:0] stat_o;         logic [1:0] bank_o;
  logic [6:0] byte_addr_i = 0; logic byte_we_i = 0; logic [7:0] byte_wdata_i = 0;
  logic [7:0] byte_rdata_o;
  logic [2:0] reg_num_i = 0;  logic reg_we_i = 0; logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic [6:0] bit_addr_i = 0; logic [1:0] bit_op_i = 0; logic bit_wdata_i = 0;
  logic       bit_rdata_o;

  int unsigned n_chk = 0, n_err = 0;
  logic [7:0] model [128];
  logic [7:0] mstat = 8'h00;

  always #4 clk_i = ~clk_i;

  iram_core dut_i (.*);

  function automatic logic [6:0] f_reg_addr(logic [7:0] st, logic [2:0] num);
    return 7'(8 * (2 * st[4] + st[3]) + num);
  endfunction

  function automatic logic [6:0] f_bit_byte(logic [6:0] b);
    return 7'(8'h20 + (b / 8));
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    stat_we_i = 0; byte_we_i = 0; reg_we_i = 0; bit_op_i = 0;
  endtask

  // inputs already driven after a falling edge
  task automatic step(bit do_chk);
    logic [6:0] ra, bb;
    logic       v;
    #1;
    ra = f_reg_addr(mstat, reg_num_i);
    bb = f_bit_byte(bit_addr_i);
    if (do_chk) begin
      chk("R5 byte read", byte_rdata_o, model[byte_addr_i]);
      chk("R3 reg read", reg_rdata_o, model[ra]);
      chk("R6 bit read", 8'(bit_rdata_o), 8'(model[bb][bit_addr_i % 8]));
      chk("R2 status", stat_o, mstat);
      chk("R2 bank", 8'(bank_o), 8'(2 * mstat[4] + mstat[3]));
    end
    @(posedge clk_i);
    if (byte_we_i) model[byte_addr_i] = byte_wdata_i;
    if (reg_we_i)  model[ra] = reg_wdata_i;
    if (bit_op_i != 0) begin
      v = (bit_op_i == 1) ? 1'b1 : (bit_op_i == 2) ? 1'b0 : bit_wdata_i;
      model[bb][bit_addr_i % 8] = v;
    end
    if (stat_we_i) mstat = stat_wdata_i;
    @(negedge clk_i);
    idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd51));
    repeat (2) @(negedge clk_i);
    #1;
    chk("R1 status in reset", stat_o, 8'h00);
    chk("R1 bank in reset", 8'(bank_o), 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk("R1 status after reset", stat_o, 8'h00);
    @(negedge clk_i);

    for (int i = 0; i < 128; i++) begin
      byte_we_i = 1; byte_addr_i = 7'(i); byte_wdata_i = 8'(i * 37 + 5);
      step(0);
    end
    for (int i = 0; i < 128; i++) begin
      byte_addr_i = 7'(i); reg_num_i = 3'(i); bit_addr_i = 7'(i);
      step(1);
    end

    // R6: bit 4Eh is bit 6 of byte 29h
    byte_we_i = 1; byte_addr_i = 7'h29; byte_wdata_i = 8'h40; step(1);
    bit_addr_i = 7'h4E; #1; chk("R6 bit 4Eh set", 8'(bit_rdata_o), 8'h01);
    byte_we_i = 1; byte_addr_i = 7'h29; byte_wdata_i = 8'hBF; step(1);
    #1; chk("R6 bit 4Eh clear", 8'(bit_rdata_o), 8'h00);

    // R7: each op on byte 2Ch (bits 60h-67h)
    byte_we_i = 1; byte_addr_i = 7'h2C; byte_wdata_i = 8'h5A; step(1);
    bit_addr_i = 7'h60; bit_op_i = 1; step(1);
    byte_addr_i = 7'h2C; #1; chk("R7 set", byte_rdata_o, 8'h5B);
    bit_addr_i = 7'h63; bit_op_i = 2; step(1);
    #1; chk("R7 clear", byte_rdata_o, 8'h53);
    bit_addr_i = 7'h67; bit_op_i = 3; bit_wdata_i = 1; step(1);
    #1; chk("R7 load 1", byte_rdata_o, 8'hD3);
    bit_addr_i = 7'h64; bit_op_i = 0; bit_wdata_i = 1; step(1);
    #1; chk("R7 nop", byte_rdata_o, 8'hD3);

    // R3 and R4: bank 3, register 5 lands at 1Dh
    stat_we_i = 1; stat_wdata_i = 8'h18; step(1);
    reg_we_i = 1; reg_num_i = 5; reg_wdata_i = 8'hA5; step(1);
    byte_addr_i = 7'h1D; #1; chk("R4 bank 3 via byte", byte_rdata_o, 8'hA5);
    byte_we_i = 1; byte_addr_i = 7'h02; byte_wdata_i = 8'h77; step(1);
    stat_we_i = 1; stat_wdata_i = 8'h00; step(1);
    reg_num_i = 2; #1; chk("R4 byte write seen in bank 0", reg_rdata_o, 8'h77);

    // R10: status write with register write, old bank 0 wins
    stat_we_i = 1; stat_wdata_i = 8'h08;
    reg_we_i = 1; reg_num_i = 3; reg_wdata_i = 8'h3C; step(1);
    byte_addr_i = 7'h03; #1; chk("R10 old bank", byte_rdata_o, 8'h3C);
    chk("R10 new bank", 8'(bank_o), 8'h01);

    // R8: byte and register on 08h, then byte and bit on 2Ah
    byte_we_i = 1; byte_addr_i = 7'h08; byte_wdata_i = 8'h11;
    reg_we_i = 1; reg_num_i = 0; reg_wdata_i = 8'h22; step(1);
    #1; chk("R8 register over byte", byte_rdata_o, 8'h22);
    byte_we_i = 1; byte_addr_i = 7'h2A; byte_wdata_i = 8'hF0;
    bit_addr_i = 7'h50; bit_op_i = 1; step(1);
    #1; chk("R8 bit over byte", byte_rdata_o, 8'hF1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      byte_addr_i = 7'($urandom); byte_we_i = ($urandom_range(0, 2) == 0);
      byte_wdata_i = 8'($urandom);
      reg_num_i = 3'($urandom); reg_we_i = ($urandom_range(0, 2) == 0);
      reg_wdata_i = 8'($urandom);
      bit_addr_i = 7'($urandom); bit_op_i = 2'($urandom); bit_wdata_i = 1'($urandom);
      stat_we_i = ($urandom_range(0, 9) == 0); stat_wdata_i = 8'($urandom);
      if ((i % 4) == 0) begin
        byte_addr_i = f_bit_byte(bit_addr_i);
      end
      step(1);
    end

    // R9: reset keeps contents, clears status
    stat_we_i = 1; stat_wdata_i = 8'hFF; step(1);
    rst_ni = 1'b0; mstat = 8'h00;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1; chk("R1 status after second reset", stat_o, 8'h00);
    for (int i = 0; i < 128; i++) begin
      byte_addr_i = 7'(i);
      #1; chk("R9 contents kept", byte_rdata_o, model[i]);
    end
    step(1);

    finish_run();
  end
endmodule